// File: doc/BRIEF.md
# Dual-Loop Phase-Frequency Detector with Lock Filter

This block holds the digital decision logic for two phase-locked loops that share one control interface. Each loop takes two single-cycle event pulses, one from the reference divider and one from the feedback divider. Both pulses are synchronous to the system clock. Each loop reports a pump command as three indications: source, sink and high impedance. A polarity bit per loop picks which phase relation drives the source side. While an error pulse is open, its width is counted in system-clock cycles. A lock filter uses these widths, with separate entry and loss thresholds and a persistence count.

The two loop lock states are merged into one lock indication. A select bit puts either that indication or one chosen divider pulse on the single shared output. This gives a way to look at the dividers from outside. Each loop has an active-low run pin. When the pin is low, that loop drops its pending phase state and its pump goes high impedance. The loop then reports itself as locked and holds its lock history until it wakes. The block also gives per-loop counter run enables and an oscillator buffer enable, which turns off only when every loop is asleep.

Top module: `dual_pfd_lock`

## Requirements
- R1: With the polarity bit high, a reference event that leads the feedback event by d cycles asserts source for d cycles. A feedback event that leads by d cycles asserts sink for d cycles. Each comparison then adds ADZ_CYC cycles of overlap, described in R3.
- R2: With the polarity bit low, the source and sink roles of R1 are exchanged.
- R3: A comparison completes on the cycle in which both events have been seen. Coincident events count as a comparison. Every completed comparison asserts source and sink together for ADZ_CYC cycles, so a zero phase error still produces pump activity.
- R4: Repeated reference events with no feedback event keep source asserted without a break until a feedback event arrives. In this case the detector acts as a frequency detector.
- R5: The high-impedance indication of a loop is high exactly when neither source nor sink is asserted.
- R6: A loop loses lock as soon as its open error pulse reaches LOSS_WIN cycles.
- R7: A loop declares lock after PERSIST consecutive comparisons, each with an error width of at most LOCK_WIN cycles. A comparison wider than LOCK_WIN restarts the count. A width strictly between LOCK_WIN and LOSS_WIN does not change an existing lock.
- R8: With the select bit low, the shared output is high only when every loop is locked or asleep.
- R9: While a loop's run pin is low, its pump is high impedance and its divider events are ignored. No flag set during sleep survives the wake-up. Its lock state is frozen and is restored on wake.
- R10: Each counter run enable follows its loop's run pin. The oscillator enable is low only when all run pins are low.
- R11: With the select bit high, the shared output carries the chosen divider pulse, delayed by one cycle. In the select field, the low bits give the loop index and the top bit picks the feedback pulse (1) or the reference pulse (0).
- R12: After reset, both loops are unlocked, no flags are set and all pumps are high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ev_i | input | NLOOP | Reference divider event pulse per loop |
| fb_ev_i | input | NLOOP | Feedback divider event pulse per loop |
| pol_i | input | NLOOP | Pump polarity per loop (1: reference lead drives source) |
| run_n_i | input | NLOOP | Per-loop run pin; low puts the loop to sleep |
| ld_sel_i | input | 1 | 1: monitor pulse on shared output, 0: combined lock |
| mon_sel_i | input | MSW | Monitor select: loop index in low bits, top bit picks feedback |
| pump_src_o | output | NLOOP | Pump source command per loop |
| pump_snk_o | output | NLOOP | Pump sink command per loop |
| pump_hiz_o | output | NLOOP | Pump high-impedance indication per loop |
| cnt_run_o | output | NLOOP | Divider counter run enable per loop |
| osc_run_o | output | 1 | Oscillator input buffer enable |
| ld_mon_o | output | 1 | Shared lock / monitor output |

## Verification
The bench builds the block with two loops, LOCK_WIN=3, LOSS_WIN=6, PERSIST=3 and ADZ_CYC=1. With these small windows, a sweep of the signed phase offset from -8 to +8 cycles, for both polarities and both loops, covers every width region. Those regions are at or below the lock threshold, between the two thresholds, and at or past the loss threshold. So the same sweep drives the lock filter into lock, holds it through the middle zone and breaks it again. A model in the bench tracks the pump cycle counts and the lock state of each comparison. It uses the arithmetic from the requirements. The two-bit monitor field is swept fully against every possible source pulse.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic src;
    logic snk;
  } pump_cmd_t;

  typedef enum logic {
    LK_OFF = 1'b0,
    LK_ON  = 1'b1
  } lock_st_t;
endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int ADZ_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  input  logic      ref_ev_i,
  input  logic      fb_ev_i,
  input  logic      pol_i,
  output pump_cmd_t cmd_o,
  output logic      flag_o,
  output logic      cmp_o
);
  localparam int ADZW = (ADZ_CYC > 0) ? $clog2(ADZ_CYC + 1) : 1;

  logic lead_q, lag_q;
  logic lead_set, lag_set, cmp;
  logic adz_on;

  assign lead_set = lead_q | ref_ev_i;
  assign lag_set  = lag_q | fb_ev_i;
  assign cmp      = run_i & lead_set & lag_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else if (!run_i || cmp) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else begin
      lead_q <= lead_set;
      lag_q  <= lag_set;
    end
  end

  generate
    if (ADZ_CYC > 0) begin : g_adz
      logic [ADZW-1:0] adz_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !run_i) adz_q <= '0;
        else if (cmp)         adz_q <= ADZW'(ADZ_CYC);
        else if (adz_q != '0) adz_q <= adz_q - 1'b1;
      end
      assign adz_on = (adz_q != '0);
    end else begin : g_no_adz
      assign adz_on = 1'b0;
    end
  endgenerate

  always_comb begin
    cmd_o.src = run_i & ((pol_i ? lead_q : lag_q) | adz_on);
    cmd_o.snk = run_i & ((pol_i ? lag_q : lead_q) | adz_on);
  end

  assign flag_o = lead_q | lag_q;
  assign cmp_o  = cmp;

  // R1: only one side of the error can be open at a time
  p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_q && lag_q));

  // R4: an open lead closes only on a feedback event or sleep
  p_lead_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lead_q) |-> ($past(fb_ev_i) || !$past(run_i)));

  // R9: sleep discards pending phase state
  p_sleep_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!lead_q && !lag_q));
endmodule

// File: rtl/lock_filter.sv
module lock_filter
  import pfd_pkg::*;
#(
  parameter int LOCK_WIN = 8,
  parameter int LOSS_WIN = 16,
  parameter int PERSIST  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic flag_i,
  input  logic cmp_i,
  output logic locked_o
);
  localparam int EW = $clog2(LOSS_WIN + 1);
  localparam int GW = $clog2(PERSIST + 1);
  localparam logic [EW:0]   LOSS_V  = (EW + 1)'(LOSS_WIN);
  localparam logic [EW:0]   LOCK_V  = (EW + 1)'(LOCK_WIN);
  localparam logic [EW-1:0] LOSS_M1 = EW'(LOSS_WIN - 1);
  localparam logic [GW-1:0] PER_V   = GW'(PERSIST);
  localparam logic [GW-1:0] PER_M1  = GW'(PERSIST - 1);

  logic [EW-1:0] err_q;
  logic [GW-1:0] good_q;
  lock_st_t      st_q;
  logic [EW:0]   width_now;
  logic          over, good_cmp;

  assign width_now = flag_i ? ({1'b0, err_q} + 1'b1) : '0;
  assign over      = (width_now >= LOSS_V);
  assign good_cmp  = cmp_i && (width_now <= LOCK_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
      st_q   <= LK_OFF;
    end else if (run_i) begin
      if (cmp_i || !flag_i)      err_q <= '0;
      else if (width_now > LOSS_V) err_q <= LOSS_V[EW-1:0];
      else                       err_q <= width_now[EW-1:0];

      if (over) begin
        st_q   <= LK_OFF;
        good_q <= '0;
      end else if (cmp_i) begin
        if (good_cmp) begin
          good_q <= (good_q == PER_V) ? good_q : good_q + 1'b1;
          if (good_q >= PER_M1) st_q <= LK_ON;
        end else begin
          good_q <= '0;
        end
      end
    end
  end

  assign locked_o = (st_q == LK_ON);

  // R7: lock is only ever declared on a comparison
  p_lock_on_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> ($past(cmp_i) && $past(run_i)));

  // R6: an error pulse reaching the loss window drops lock
  p_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && flag_i && !cmp_i && err_q >= LOSS_M1) |=> !locked_o);

  // R9: lock history is frozen during sleep
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(locked_o));
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
  import pfd_pkg::*;
#(
  parameter int NLOOP    = 2,
  parameter int LOCK_WIN = 8,
  parameter int LOSS_WIN = 16,
  parameter int PERSIST  = 3,
  parameter int ADZ_CYC  = 2,
  parameter int LW       = (NLOOP > 1) ? $clog2(NLOOP) : 1,
  parameter int MSW      = LW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLOOP-1:0] ref_ev_i,
  input  logic [NLOOP-1:0] fb_ev_i,
  input  logic [NLOOP-1:0] pol_i,
  input  logic [NLOOP-1:0] run_n_i,
  input  logic             ld_sel_i,
  input  logic [MSW-1:0]   mon_sel_i,
  output logic [NLOOP-1:0] pump_src_o,
  output logic [NLOOP-1:0] pump_snk_o,
  output logic [NLOOP-1:0] pump_hiz_o,
  output logic [NLOOP-1:0] cnt_run_o,
  output logic             osc_run_o,
  output logic             ld_mon_o
);
  logic [NLOOP-1:0] locked, ld_loop;
  logic             ld_all;
  logic             mon_q, mon_pick;
  logic [LW-1:0]    mon_idx;

  generate
    for (genvar g = 0; g < NLOOP; g++) begin : g_loop
      pump_cmd_t cmd;
      logic      flag, cmp;

      pfd_core #(.ADZ_CYC(ADZ_CYC)) u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_n_i[g]),
        .ref_ev_i (ref_ev_i[g]),
        .fb_ev_i  (fb_ev_i[g]),
        .pol_i    (pol_i[g]),
        .cmd_o    (cmd),
        .flag_o   (flag),
        .cmp_o    (cmp)
      );

      lock_filter #(
        .LOCK_WIN (LOCK_WIN),
        .LOSS_WIN (LOSS_WIN),
        .PERSIST  (PERSIST)
      ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_n_i[g]),
        .flag_i   (flag),
        .cmp_i    (cmp),
        .locked_o (locked[g])
      );

      assign pump_src_o[g] = cmd.src;
      assign pump_snk_o[g] = cmd.snk;
      assign pump_hiz_o[g] = ~(cmd.src | cmd.snk);
      assign ld_loop[g]    = ~run_n_i[g] | locked[g];

      // R5: high impedance exactly when no pump command is active
      p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pump_hiz_o[g] == !(pump_src_o[g] || pump_snk_o[g]));
    end
  endgenerate

  assign ld_all    = &ld_loop;
  assign cnt_run_o = run_n_i;
  assign osc_run_o = |run_n_i;

  assign mon_idx = mon_sel_i[LW-1:0];
  always_comb begin
    mon_pick = 1'b0;
    for (int i = 0; i < NLOOP; i++) begin
      if (mon_idx == LW'(i))
        mon_pick = mon_sel_i[MSW-1] ? fb_ev_i[i] : ref_ev_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mon_q <= 1'b0;
    else        mon_q <= mon_pick;
  end

  assign ld_mon_o = ld_sel_i ? mon_q : ld_all;

  // R8: all loops asleep reads as locked
  p_all_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_sel_i && run_n_i == '0) |-> ld_mon_o);

  // R10: the oscillator stays enabled while any loop runs
  p_osc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n_i != '0) |-> osc_run_o);

  // R9: a sleeping loop never drives its pump
  p_sleep_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pump_src_o | pump_snk_o) & ~run_n_i) == '0);
endmodule

// File: tb/test_dual_pfd_lock.sv
module test_dual_pfd_lock;
  localparam int NL = 2;
  localparam int LKW = 3;
  localparam int LSW = 6;
  localparam int PER = 3;
  localparam int ADZ = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] ref_ev = '0, fb_ev = '0, pol = '1, run_n = '1;
  logic          ld_sel = 1'b0;
  logic [1:0]    mon_sel = '0;
  logic [NL-1:0] src, snk, hiz, cnt_run;
  logic          osc_run, ld_mon;

  int n_cmp = 0;
  int n_bad = 0;
  int m_good [NL];
  int m_lock [NL];

  always #10 clk = ~clk;

  dual_pfd_lock #(
    .NLOOP(NL), .LOCK_WIN(LKW), .LOSS_WIN(LSW), .PERSIST(PER), .ADZ_CYC(ADZ)
  ) i_dual_pfd_lock (
    .clk(clk), .rst_n(rst_n), .ref_ev_i(ref_ev), .fb_ev_i(fb_ev),
    .pol_i(pol), .run_n_i(run_n), .ld_sel_i(ld_sel), .mon_sel_i(mon_sel),
    .pump_src_o(src), .pump_snk_o(snk), .pump_hiz_o(hiz),
    .cnt_run_o(cnt_run), .osc_run_o(osc_run), .ld_mon_o(ld_mon)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one comparison with signed offset d (d>0: reference leads).
  task automatic pair(input int lp, input int d, input bit upd,
                      output int ns, output int nk, output int nz, output int it);
    int ad, rt, ft;
    ad = (d < 0) ? -d : d;
    rt = (d < 0) ? ad : 0;
    ft = (d > 0) ? ad : 0;
    ns = 0; nk = 0; nz = 0;
    it = ad + ADZ + 6;
    for (int t = 0; t < it; t++) begin
      @(negedge clk);
      ns += int'(src[lp]);
      nk += int'(snk[lp]);
      nz += int'(hiz[lp]);
      ref_ev[lp] = (t == rt);
      fb_ev[lp]  = (t == ft);
    end
    if (upd) begin
      if (ad >= LSW) begin
        m_good[lp] = 0; m_lock[lp] = 0;
      end else if (ad <= LKW) begin
        if (m_good[lp] < PER) m_good[lp]++;
        if (m_good[lp] >= PER) m_lock[lp] = 1;
      end else begin
        m_good[lp] = 0;
      end
    end
  endtask

  function automatic int exp_ld();
    int v = 1;
    for (int i = 0; i < NL; i++)
      if (run_n[i] && !m_lock[i]) v = 0;
    return v;
  endfunction

  task automatic pair_chk(input int lp, input int d, input string tag);
    int ns, nk, nz, it, ad, lead, lag, es, ek;
    pair(lp, d, 1'b1, ns, nk, nz, it);
    ad = (d < 0) ? -d : d;
    lead = (d > 0) ? d : 0;
    lag  = (d < 0) ? -d : 0;
    es = (pol[lp] ? lead : lag) + ADZ;
    ek = (pol[lp] ? lag : lead) + ADZ;
    check({tag, " src cycles"}, ns, es);
    check({tag, " snk cycles"}, nk, ek);
    check("R5 hiz cycles", nz, it - ad - ADZ);
    check("R6/R7 lock after comparison", int'(ld_mon), exp_ld());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int ns, nk, nz, it;
    for (int i = 0; i < NL; i++) begin m_good[i] = 0; m_lock[i] = 0; end
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12 hiz", int'(hiz), 3);
    check("R12 src", int'(src), 0);
    check("R12 snk", int'(snk), 0);
    check("R12 ld", int'(ld_mon), 0);
    check("R10 osc at reset", int'(osc_run), 1);

    // R1 R2 R3 R6 R7: sweep of offsets, both polarities, each loop isolated
    for (int lp = 0; lp < NL; lp++) begin
      run_n = (lp == 0) ? 2'b01 : 2'b10;
      for (int pv = 1; pv >= 0; pv--) begin
        pol[lp] = pv[0];
        for (int d = -8; d <= 8; d++)
          pair_chk(lp, d, pv ? "R1" : "R2");
      end
      pol[lp] = 1'b1;
    end

    // R7: a mid-zone width restarts the persistence count
    run_n = 2'b01;
    pair_chk(0, 8, "R6");
    pair_chk(0, 1, "R7");
    pair_chk(0, 1, "R7");
    pair_chk(0, 4, "R7");
    pair_chk(0, 1, "R7");
    pair_chk(0, -1, "R7");
    check("R7 not yet locked", int'(ld_mon), 0);
    pair_chk(0, 0, "R3");
    check("R7 locked after third", int'(ld_mon), 1);

    // R4: repeated reference events keep source held
    run_n = 2'b11;
    pair_chk(1, 8, "R6");
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      ns = (t == 0) ? 0 : ns + int'(src[1]);
      ref_ev[1] = (t == 0 || t == 4 || t == 8);
      fb_ev[1]  = (t == 12);
    end
    m_good[1] = 0; m_lock[1] = 0;
    check("R4 held source cycles", ns, 12 + ADZ);

    // R8: combined lock over both running loops
    check("R8 one unlocked", int'(ld_mon), 0);
    for (int k = 0; k < PER; k++) pair_chk(1, 0, "R3");
    check("R8 both locked", int'(ld_mon), 1);
    pair_chk(0, 7, "R6");
    check("R8 loop0 lost", int'(ld_mon), 0);
    for (int k = 0; k < PER; k++) pair_chk(0, 1, "R1");
    check("R8 relocked", int'(ld_mon), 1);

    // R9 R10: sleep on loop 0
    run_n = 2'b10;
    @(negedge clk);
    check("R9 hiz in sleep", int'(hiz[0]), 1);
    check("R10 cnt_run", int'(cnt_run), 2);
    check("R10 osc one running", int'(osc_run), 1);
    pair(0, 8, 1'b0, ns, nk, nz, it);
    check("R9 no src in sleep", ns, 0);
    check("R9 no snk in sleep", nk, 0);
    check("R9 ld while asleep", int'(ld_mon), 1);
    pair_chk(1, 8, "R6");
    check("R8 loop1 unlocked, loop0 asleep", int'(ld_mon), 0);
    run_n = 2'b00;
    @(negedge clk);
    check("R10 osc all asleep", int'(osc_run), 0);
    check("R8 all asleep", int'(ld_mon), 1);
    ref_ev[0] = 1'b1;
    @(negedge clk);
    ref_ev[0] = 1'b0;
    @(negedge clk);
    run_n = 2'b01;
    @(negedge clk);
    check("R9 lock restored on wake", int'(ld_mon), 1);
    pair(0, -2, 1'b1, ns, nk, nz, it);
    check("R9 stale flag src", ns, ADZ);
    check("R9 stale flag snk", nk, 2 + ADZ);

    // R11: monitor select sweep (field: bit0 loop, bit1 feedback)
    run_n = 2'b00;
    ld_sel = 1'b1;
    for (int s = 0; s < 4; s++) begin
      mon_sel = s[1:0];
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (k[1]) fb_ev[k[0]] = 1'b1; else ref_ev[k[0]] = 1'b1;
        @(negedge clk);
        ref_ev = '0; fb_ev = '0;
        check("R11 monitor pulse", int'(ld_mon), (k == s) ? 1 : 0);
        @(negedge clk);
        check("R11 monitor idle", int'(ld_mon), 0);
      end
    end
    ld_sel = 1'b0;
    @(negedge clk);
    check("R8 back to lock view", int'(ld_mon), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule